// File: doc/BRIEF.md
# Stalling FIFO Port Bridge

This block sits between the byte-wide port interface of a small 8-bit controller (a port address, an output byte, an input byte, a write strobe and a read strobe) and two synchronous FIFOs. One FIFO carries bytes from the controller to a consumer. The other carries bytes from a producer to the controller. When the controller writes to the data port while the outgoing FIFO is full, the bridge raises a busy line. The controller's port instruction then waits until space appears, and the byte is written at that point. When the controller reads the data port while the incoming FIFO is empty, the bridge raises the same busy line until the producer delivers a byte, and then returns that byte.

Because the controller is held in place rather than throttled early, both FIFOs can be filled to their full depth. A strobe that is held high for several cycles transfers exactly one byte. Two further port addresses return the fill level of each FIFO, so firmware can poll how much room or data there is without moving any entry.

Top module: `fifo_port_bridge`

## Requirements
- R1: Only an access whose portId equals DATA_PORT (default 8'h20) can raise portBusy; a strobe on any other address never raises portBusy and moves no FIFO entry.
- R2: A write strobe to DATA_PORT while the outgoing FIFO is full holds portBusy high and adds no entry; once an entry leaves, the held outPort byte is written and portBusy falls.
- R3: A write strobe to DATA_PORT that stays high for several cycles adds exactly one entry.
- R4: A read strobe to DATA_PORT while the incoming FIFO is empty holds portBusy high; after the producer delivers a byte, portBusy falls and inPort carries that byte in that same cycle.
- R5: A read strobe to DATA_PORT that stays high for several cycles removes exactly one entry.
- R6: Each FIFO accepts DEPTH entries (default 16) with no stall; prodReady is low only while the incoming FIFO holds DEPTH entries.
- R7: Bytes leave each FIFO in the order they entered.
- R8: A read of TX_LEVEL_PORT (8'h21) or RX_LEVEL_PORT (8'h22) returns the occupancy of the outgoing or incoming FIFO, zero-extended to 8 bits, and removes no entry; any other non-data address reads as 0.
- R9: After reset, both FIFOs are empty, portBusy is low, consValid is low and prodReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| portId | input | 8 | Port address from the controller |
| outPort | input | 8 | Byte written by the controller |
| writeStrobe | input | 1 | Controller write strobe, held while portBusy is high |
| readStrobe | input | 1 | Controller read strobe, held while portBusy is high |
| inPort | output | 8 | Byte returned to the controller |
| portBusy | output | 1 | Holds the controller's port instruction |
| prodData | input | 8 | Producer byte for the incoming FIFO |
| prodValid | input | 1 | Producer byte valid |
| prodReady | output | 1 | Incoming FIFO can accept a byte |
| consData | output | 8 | Head byte of the outgoing FIFO |
| consValid | output | 1 | Outgoing FIFO holds a byte |
| consReady | input | 1 | Consumer takes the head byte |

## Verification
The hardest situation to reach is a write that is already stalled on a full FIFO and must complete with its held byte in the correct place in the order. The bench first fills the outgoing FIFO to its full depth with the consumer idle. It then issues one more write, and in a parallel thread lets the consumer take exactly one byte after several stall cycles. The scoreboard then confirms that the stalled byte comes out last. The opposite case, a read that waits on an empty FIFO and is released by a producer byte arriving during the stall, is set up in the same way.

// File: rtl/fifo_bridge_pkg.sv
package fifo_bridge_pkg;

  typedef enum logic [1:0] {
    IN_SEL_ZERO  = 2'd0,
    IN_SEL_DATA  = 2'd1,
    IN_SEL_TXLVL = 2'd2,
    IN_SEL_RXLVL = 2'd3
  } inSel_e;

  typedef struct packed {
    logic   txPush;
    logic   rxPop;
    inSel_e inSel;
  } bridgeStrobes_t;

endpackage

// File: rtl/fbr_fifo.sv
module fbr_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic             doPush;
  logic             doPop;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/fbr_ctrl.sv
module fbr_ctrl
  import fifo_bridge_pkg::*;
#(
  parameter logic [7:0] DATA_PORT    = 8'h20,
  parameter logic [7:0] TX_LEVEL_PORT = 8'h21,
  parameter logic [7:0] RX_LEVEL_PORT = 8'h22
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [7:0]     portId,
  input  logic           writeStrobe,
  input  logic           readStrobe,
  input  logic           txFull,
  input  logic           rxEmpty,
  output logic           portBusy,
  output bridgeStrobes_t strobes
);

  logic dataHit;
  logic wrDone;
  logic rdDone;
  logic wrLive;
  logic rdLive;

  assign dataHit = (portId == DATA_PORT);
  // a strobe is live until its single transfer has happened
  assign wrLive  = writeStrobe && dataHit && !wrDone;
  assign rdLive  = readStrobe && dataHit && !rdDone;

  always_comb begin
    strobes.txPush = wrLive && !txFull;
    strobes.rxPop  = rdLive && !rxEmpty;
    if (dataHit)                  strobes.inSel = IN_SEL_DATA;
    else if (portId == TX_LEVEL_PORT) strobes.inSel = IN_SEL_TXLVL;
    else if (portId == RX_LEVEL_PORT) strobes.inSel = IN_SEL_RXLVL;
    else                          strobes.inSel = IN_SEL_ZERO;
    portBusy = (wrLive && txFull) || (rdLive && rxEmpty);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrDone <= 1'b0;
      rdDone <= 1'b0;
    end else begin
      wrDone <= writeStrobe && (wrDone || strobes.txPush);
      rdDone <= readStrobe && (rdDone || strobes.rxPop);
    end
  end

endmodule

// File: rtl/fbr_datapath.sv
module fbr_datapath
  import fifo_bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  bridgeStrobes_t strobes,
  input  logic [7:0]     outPort,
  output logic [7:0]     inPort,
  input  logic [7:0]     prodData,
  input  logic           prodValid,
  output logic           prodReady,
  output logic [7:0]     consData,
  output logic           consValid,
  input  logic           consReady,
  output logic           txFull,
  output logic           rxEmpty,
  output logic [CW-1:0]  txLevel,
  output logic [CW-1:0]  rxLevel
);

  logic       txEmpty;
  logic       rxFull;
  logic [7:0] rxHead;
  logic [7:0] txLvl8;
  logic [7:0] rxLvl8;

  fbr_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pushData(outPort),
    .pop(consReady), .popData(consData),
    .full(txFull), .empty(txEmpty), .level(txLevel)
  );

  fbr_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(prodValid), .pushData(prodData),
    .pop(strobes.rxPop), .popData(rxHead),
    .full(rxFull), .empty(rxEmpty), .level(rxLevel)
  );

  assign consValid = !txEmpty;
  assign prodReady = !rxFull;

  always_comb begin
    txLvl8 = '0;
    rxLvl8 = '0;
    txLvl8[CW-1:0] = txLevel;
    rxLvl8[CW-1:0] = rxLevel;
    case (strobes.inSel)
      IN_SEL_DATA:  inPort = rxHead;
      IN_SEL_TXLVL: inPort = txLvl8;
      IN_SEL_RXLVL: inPort = rxLvl8;
      default:      inPort = 8'h00;
    endcase
  end

endmodule

// File: rtl/fifo_port_bridge.sv
module fifo_port_bridge
  import fifo_bridge_pkg::*;
#(
  parameter int         DEPTH         = 16,
  parameter logic [7:0] DATA_PORT     = 8'h20,
  parameter logic [7:0] TX_LEVEL_PORT = 8'h21,
  parameter logic [7:0] RX_LEVEL_PORT = 8'h22
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] portId,
  input  logic [7:0] outPort,
  input  logic       writeStrobe,
  input  logic       readStrobe,
  output logic [7:0] inPort,
  output logic       portBusy,
  input  logic [7:0] prodData,
  input  logic       prodValid,
  output logic       prodReady,
  output logic [7:0] consData,
  output logic       consValid,
  input  logic       consReady
);

  localparam int CW = $clog2(DEPTH) + 1;

  initial begin
    if (CW > 8 || DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
      $error("DEPTH must be a power of two from 2 to 128");
  end

  bridgeStrobes_t strobes;
  logic           txFull;
  logic           rxEmpty;
  logic [CW-1:0]  txLevel;
  logic [CW-1:0]  rxLevel;

  fbr_ctrl #(
    .DATA_PORT(DATA_PORT), .TX_LEVEL_PORT(TX_LEVEL_PORT), .RX_LEVEL_PORT(RX_LEVEL_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portId(portId),
    .writeStrobe(writeStrobe), .readStrobe(readStrobe),
    .txFull(txFull), .rxEmpty(rxEmpty),
    .portBusy(portBusy), .strobes(strobes)
  );

  fbr_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .outPort(outPort), .inPort(inPort),
    .prodData(prodData), .prodValid(prodValid), .prodReady(prodReady),
    .consData(consData), .consValid(consValid), .consReady(consReady),
    .txFull(txFull), .rxEmpty(rxEmpty), .txLevel(txLevel), .rxLevel(rxLevel)
  );

endmodule

// File: rtl/fifo_port_bridge_checker.sv
module fifo_port_bridge_checker #(
  parameter int         DEPTH     = 16,
  parameter logic [7:0] DATA_PORT = 8'h20,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic [7:0]    portId,
  input logic          writeStrobe,
  input logic          readStrobe,
  input logic          portBusy,
  input logic          prodReady,
  input logic [CW-1:0] txLevel,
  input logic [CW-1:0] rxLevel
);

  logic dataHit;
  assign dataHit = (portId == DATA_PORT);

  assert_busy_only_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    portBusy |-> (dataHit && (writeStrobe || readStrobe)));

  assert_no_push_in_stall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (portBusy && writeStrobe) |=> (txLevel <= $past(txLevel)));

  assert_single_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    (writeStrobe && dataHit && $past(writeStrobe && dataHit && !portBusy))
      |=> (txLevel <= $past(txLevel)));

  assert_read_stall_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (portBusy && readStrobe) |-> (rxLevel == '0));

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && dataHit && $past(readStrobe && dataHit && !portBusy))
      |=> (rxLevel >= $past(rxLevel)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= CW'(DEPTH)) && (rxLevel <= CW'(DEPTH)));

  assert_ready_when_room_R6: assert property (@(posedge clk) disable iff (!rstN)
    !prodReady |-> (rxLevel == CW'(DEPTH)));

endmodule

bind fifo_port_bridge fifo_port_bridge_checker #(
  .DEPTH(DEPTH), .DATA_PORT(DATA_PORT)
) u_checker (
  .clk(clk), .rstN(rstN), .portId(portId),
  .writeStrobe(writeStrobe), .readStrobe(readStrobe),
  .portBusy(portBusy), .prodReady(prodReady),
  .txLevel(txLevel), .rxLevel(rxLevel)
);

// File: tb/fifo_port_bridge_tb.sv
module fifo_port_bridge_tb;

  localparam int         DEPTH = 16;
  localparam logic [7:0] DATA  = 8'h20;
  localparam logic [7:0] TXLVL = 8'h21;
  localparam logic [7:0] RXLVL = 8'h22;
  localparam logic [7:0] OTHER = 8'h30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] portId = '0;
  logic [7:0] outPort = '0;
  logic       writeStrobe = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] inPort;
  logic       portBusy;
  logic [7:0] prodData = '0;
  logic       prodValid = 1'b0;
  logic       prodReady;
  logic [7:0] consData;
  logic       consValid;
  logic       consReady = 1'b0;

  int tests = 0;
  int fails = 0;
  logic [7:0] txExp[$];
  logic [7:0] rxExp[$];

  always #2 clk = ~clk;

  fifo_port_bridge #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .portId(portId), .outPort(outPort),
    .writeStrobe(writeStrobe), .readStrobe(readStrobe),
    .inPort(inPort), .portBusy(portBusy),
    .prodData(prodData), .prodValid(prodValid), .prodReady(prodReady),
    .consData(consData), .consValid(consValid), .consReady(consReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor for the consumer side
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && consValid && consReady) begin
        if (txExp.size() == 0) check(0, "R7", "unexpected consumer byte", consData, -1);
        else begin
          logic [7:0] e;
          e = txExp.pop_front();
          check(consData == e, "R7", "consumer byte order", consData, e);
        end
      end
    end
  end

  task automatic ctrlWrite(input logic [7:0] port, input logic [7:0] data,
                           input int holdExtra, output int stalls);
    stalls = 0;
    @(negedge clk);
    portId = port; outPort = data; writeStrobe = 1'b1;
    if (port == DATA) txExp.push_back(data);
    forever begin
      #1;
      if (!portBusy) break;
      stalls++;
      @(negedge clk);
    end
    repeat (holdExtra + 1) @(negedge clk);
    writeStrobe = 1'b0;
  endtask

  task automatic ctrlRead(input logic [7:0] port, input int holdExtra,
                          output logic [7:0] data, output int stalls);
    stalls = 0;
    @(negedge clk);
    portId = port; readStrobe = 1'b1;
    forever begin
      #1;
      if (!portBusy) break;
      stalls++;
      @(negedge clk);
    end
    data = inPort;
    if (port == DATA) begin
      logic [7:0] e;
      e = (rxExp.size() > 0) ? rxExp.pop_front() : 8'hxx;
      check(data == e, "R7", "controller read byte", data, e);
    end
    repeat (holdExtra + 1) @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic prodPush(input logic [7:0] data, output bit taken);
    @(negedge clk);
    prodData = data; prodValid = 1'b1;
    #1;
    taken = prodReady;
    if (taken) rxExp.push_back(data);
    @(negedge clk);
    prodValid = 1'b0;
  endtask

  task automatic drainTx();
    @(negedge clk);
    consReady = 1'b1;
    repeat (DEPTH + 4) @(negedge clk);
    consReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int st;
    logic [7:0] rd;
    bit tk;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(portBusy == 0, "R9", "portBusy after reset", portBusy, 0);
    check(consValid == 0, "R9", "consValid after reset", consValid, 0);
    check(prodReady == 1, "R9", "prodReady after reset", prodReady, 1);
    ctrlRead(TXLVL, 0, rd, st);
    check(rd == 0, "R8", "tx level after reset", rd, 0);
    ctrlRead(RXLVL, 0, rd, st);
    check(rd == 0, "R8", "rx level after reset", rd, 0);

    // fill outgoing FIFO to full depth with no stall
    begin
      int totalStall = 0;
      for (int i = 0; i < DEPTH; i++) begin
        ctrlWrite(DATA, 8'(8'h40 + i), 0, st);
        totalStall += st;
      end
      check(totalStall == 0, "R6", "stalls while filling outgoing FIFO", totalStall, 0);
    end
    ctrlRead(TXLVL, 0, rd, st);
    check(rd == DEPTH, "R6", "tx level when full", rd, DEPTH);

    // R1: other port while full never stalls
    ctrlWrite(OTHER, 8'hEE, 0, st);
    check(st == 0, "R1", "stalls on other-port write", st, 0);
    ctrlRead(TXLVL, 0, rd, st);
    check(rd == DEPTH, "R1", "tx level after other-port write", rd, DEPTH);

    // R2: stalled write on full FIFO, released by one consumer pop
    fork
      ctrlWrite(DATA, 8'hC7, 0, st);
      begin
        repeat (6) @(negedge clk);
        consReady = 1'b1;
        @(negedge clk);
        consReady = 1'b0;
      end
    join
    check(st >= 5, "R2", "stall cycles on full write", st, 5);
    ctrlRead(TXLVL, 0, rd, st);
    check(rd == DEPTH, "R2", "tx level after stalled write", rd, DEPTH);
    drainTx();
    check(txExp.size() == 0, "R7", "outgoing bytes left unchecked", txExp.size(), 0);
    check(consValid == 0, "R7", "consValid after drain", consValid, 0);

    // R3: held write strobe adds one entry
    ctrlWrite(DATA, 8'hA5, 5, st);
    ctrlRead(TXLVL, 0, rd, st);
    check(rd == 1, "R3", "tx level after held strobe", rd, 1);
    drainTx();
    check(txExp.size() == 0, "R3", "held-strobe bytes left", txExp.size(), 0);

    // R1: read of other port with incoming FIFO empty
    ctrlRead(OTHER, 0, rd, st);
    check(st == 0, "R1", "stalls on other-port read", st, 0);
    check(rd == 0, "R8", "other-port read value", rd, 0);

    // R4: read stall on empty, released by producer
    fork
      ctrlRead(DATA, 0, rd, st);
      begin
        repeat (4) @(negedge clk);
        prodPush(8'h3C, tk);
      end
    join
    check(st >= 4, "R4", "stall cycles on empty read", st, 4);
    check(rd == 8'h3C, "R4", "byte after empty stall", rd, 8'h3C);

    // R6: incoming FIFO takes DEPTH entries, refuses one more
    begin
      int taken = 0;
      for (int i = 0; i < DEPTH; i++) begin
        prodPush(8'(8'h80 + i), tk);
        taken += int'(tk);
      end
      check(taken == DEPTH, "R6", "producer bytes accepted", taken, DEPTH);
    end
    #1;
    check(prodReady == 0, "R6", "prodReady when incoming full", prodReady, 0);
    prodPush(8'hFF, tk);
    check(tk == 0, "R6", "byte accepted beyond depth", tk, 0);
    ctrlRead(RXLVL, 0, rd, st);
    check(rd == DEPTH, "R8", "rx level when full", rd, DEPTH);

    // R5: held read strobe removes one entry
    ctrlRead(DATA, 4, rd, st);
    ctrlRead(RXLVL, 0, rd, st);
    check(rd == DEPTH - 1, "R5", "rx level after held read", rd, DEPTH - 1);
    for (int i = 0; i < DEPTH - 1; i++) ctrlRead(DATA, 0, rd, st);
    check(rxExp.size() == 0, "R7", "incoming bytes left unchecked", rxExp.size(), 0);
    ctrlRead(RXLVL, 0, rd, st);
    check(rd == 0, "R8", "rx level after draining", rd, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule